// File: doc/BRIEF.md
# Global Shutter Exposure Sequencer

This block runs the exposure of a global-shutter pixel core. A begin request starts a fixed core-reset phase. The core-reset phase leads into an integration phase that counts coarse time units. When the programmed length is reached, a timer flag rises. An end request then starts a fixed transfer phase, which leaves the core ready to be read out. Every phase advances on a coarse step enable. A programmable divider derives this enable from the system clock.

Both requests are captured on the falling edge of the system clock. While either captured request is high, the sequencer is suspended. In that state the divider is held at zero and no phase counter moves. A phase therefore always runs its full length, measured from the clock edge after the request is released. The end request may be driven from the timer flag. The two requests must remain separate signals.

Top module: `gs_expo_seq`

## Requirements
- R1: After a synchronous reset, `phase_o` is 0 (idle), `ready_o` is 0 and `expo_done_o` is 0.
- R2: Both requests are sampled on the falling clock edge. While either sampled request is high, no step enable is produced and the core-reset and transfer phases hold their position. The divider restarts at zero on release, so phase lengths do not depend on how long a request was held.
- R3: One coarse step lasts R = 2^`div_sel_i` system clocks, with `div_sel_i` values 0..3 giving 1, 2, 4 or 8.
- R4: A begin request accepted in idle moves `phase_o` to 1 (core reset) on the next rising edge. Counting rising edges from the first unsuspended one as 1, `phase_o` becomes 2 (integrating) at edge 4R.
- R5: During integration the counter advances once per step. `expo_done_o` rises at edge (4+T)·R, counted as in R4, where T is `expo_len_i`.
- R6: `expo_done_o` stays high for exactly one step (R clocks). It is cleared on the same edge that accepts an end request.
- R7: With `expo_len_i` = 0, `expo_done_o` never rises.
- R8: An end request sampled during integration moves `phase_o` to 3 (transfer) on the next edge. Counting edges from the first unsuspended one, `ready_o` rises and `phase_o` returns to 0 at edge 2R.
- R9: An end request in idle or core reset is ignored. `phase_o` and `ready_o` are unchanged afterwards.
- R10: A begin request during transfer is held back. When transfer ends, `phase_o` goes to 1 and `ready_o` stays 0.
- R11: `ready_o` stays high in idle until the next accepted begin request, which clears it on the edge that enters core reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| div_sel_i | input | SEL_W | Step divider select, ratio 2^value |
| expo_len_i | input | INT_W | Integration length in steps |
| expo_begin_i | input | 1 | Begin request, sampled on falling edge |
| expo_end_i | input | 1 | End request, sampled on falling edge |
| expo_done_o | output | 1 | Integration length reached, one step wide |
| ready_o | output | 1 | Core is in its readable state |
| phase_o | output | 2 | 0 idle, 1 core reset, 2 integrating, 3 transfer |

## Verification
The bench builds the block with INT_W = 8, SEL_W = 2 and the default phase lengths of four and two steps. All four divider ratios, from one to eight clocks, are therefore reachable, and short integration lengths complete in tens of cycles. Because the ratio can be set to 8, a begin request can land inside the transfer phase and the held-back restart can be observed. Zero length and long request holds are reached with the same build.

// File: rtl/gs_expo_pkg.sv
package gs_expo_pkg;
  typedef enum logic [1:0] {
    PH_IDLE     = 2'd0,
    PH_CORE_RST = 2'd1,
    PH_INTEG    = 2'd2,
    PH_XFER     = 2'd3
  } phase_t;
endpackage

// File: rtl/gs_req_sample.sv
module gs_req_sample #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] req_i,
  output logic [N-1:0] req_s_o
);
  // One falling-edge capture flop per request line.
  for (genvar i = 0; i < N; i++) begin : g_line
    always_ff @(negedge clk) begin
      if (rst) req_s_o[i] <= 1'b0;
      else     req_s_o[i] <= req_i[i];
    end
  end
endmodule

// File: rtl/gs_step_div.sv
module gs_step_div #(
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             hold_i,
  output logic             tick_o
);
  localparam int CNT_W = (2 ** SEL_W) - 1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] last;

  always_comb begin
    last   = CNT_W'((32'd1 << sel_i) - 32'd1);
    tick_o = !hold_i && (cnt == last);
  end

  always_ff @(posedge clk) begin
    if (rst || hold_i) cnt <= '0;
    else if (tick_o)   cnt <= '0;
    else               cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/gs_expo_fsm.sv
module gs_expo_fsm
  import gs_expo_pkg::*;
#(
  parameter int INT_W       = 16,
  parameter int RST_PERIODS = 4,
  parameter int XFR_PERIODS = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic             begin_s_i,
  input  logic             end_s_i,
  input  logic [INT_W-1:0] len_i,
  output phase_t           phase_o,
  output logic             ready_o,
  output logic             done_o
);
  localparam int STEP_MAX = (RST_PERIODS > XFR_PERIODS) ? RST_PERIODS : XFR_PERIODS;
  localparam int STEP_W   = (STEP_MAX > 1) ? $clog2(STEP_MAX) : 1;
  localparam logic [STEP_W-1:0] RST_LAST = STEP_W'(RST_PERIODS - 1);
  localparam logic [STEP_W-1:0] XFR_LAST = STEP_W'(XFR_PERIODS - 1);
  localparam logic [INT_W-1:0]  ICNT_MAX = '1;

  phase_t            phase;
  logic [STEP_W-1:0] step;
  logic [INT_W-1:0]  icnt;
  logic [INT_W-1:0]  icnt_nxt;
  logic              pend;
  logic              hit;

  always_comb begin
    icnt_nxt = (icnt == ICNT_MAX) ? icnt : icnt + 1'b1;
    hit      = (len_i != '0) && (icnt != ICNT_MAX) && (icnt_nxt == len_i);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= PH_IDLE;
      step    <= '0;
      icnt    <= '0;
      pend    <= 1'b0;
      ready_o <= 1'b0;
      done_o  <= 1'b0;
    end else begin
      unique case (phase)
        PH_IDLE: begin
          if (begin_s_i) begin
            phase   <= PH_CORE_RST;
            step    <= '0;
            ready_o <= 1'b0;
          end
        end
        PH_CORE_RST: begin
          if (tick_i) begin
            if (step == RST_LAST) begin
              phase <= PH_INTEG;
              step  <= '0;
              icnt  <= '0;
            end else begin
              step <= step + 1'b1;
            end
          end
        end
        PH_INTEG: begin
          if (end_s_i) begin
            phase  <= PH_XFER;
            step   <= '0;
            pend   <= 1'b0;
            done_o <= 1'b0;
          end else if (tick_i) begin
            icnt <= icnt_nxt;
            if (done_o)   done_o <= 1'b0;
            else if (hit) done_o <= 1'b1;
          end
        end
        PH_XFER: begin
          if (begin_s_i) pend <= 1'b1;
          if (tick_i) begin
            if (step == XFR_LAST) begin
              step <= '0;
              pend <= 1'b0;
              if (pend) begin
                phase <= PH_CORE_RST;
              end else begin
                phase   <= PH_IDLE;
                ready_o <= 1'b1;
              end
            end else begin
              step <= step + 1'b1;
            end
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assign phase_o = phase;
endmodule

// File: rtl/gs_expo_seq.sv
module gs_expo_seq
  import gs_expo_pkg::*;
#(
  parameter int INT_W       = 16,
  parameter int SEL_W       = 2,
  parameter int RST_PERIODS = 4,
  parameter int XFR_PERIODS = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] div_sel_i,
  input  logic [INT_W-1:0] expo_len_i,
  input  logic             expo_begin_i,
  input  logic             expo_end_i,
  output logic             expo_done_o,
  output logic             ready_o,
  output logic [1:0]       phase_o
);
  logic [1:0] req_s;
  logic       begin_s;
  logic       end_s;
  logic       hold;
  logic       gran_tick;
  phase_t     phase;

  gs_req_sample #(.N(2)) u_sample (
    .clk     (clk),
    .rst     (rst),
    .req_i   ({expo_end_i, expo_begin_i}),
    .req_s_o (req_s)
  );

  assign begin_s = req_s[0];
  assign end_s   = req_s[1];
  assign hold    = begin_s | end_s;

  gs_step_div #(.SEL_W(SEL_W)) u_div (
    .clk    (clk),
    .rst    (rst),
    .sel_i  (div_sel_i),
    .hold_i (hold),
    .tick_o (gran_tick)
  );

  gs_expo_fsm #(
    .INT_W       (INT_W),
    .RST_PERIODS (RST_PERIODS),
    .XFR_PERIODS (XFR_PERIODS)
  ) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .tick_i    (gran_tick),
    .begin_s_i (begin_s),
    .end_s_i   (end_s),
    .len_i     (expo_len_i),
    .phase_o   (phase),
    .ready_o   (ready_o),
    .done_o    (expo_done_o)
  );

  assign phase_o = phase;
endmodule

// File: rtl/gs_expo_seq_chk.sv
module gs_expo_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic [1:0] phase,
  input logic       ready,
  input logic       done,
  input logic       hold,
  input logic       begin_s
);
  // R2: a held request freezes the core-reset phase
  a_r2_hold_core_rst: assert property (@(posedge clk) disable iff (rst)
    (phase == 2'd1 && hold) |=> (phase == 2'd1));

  // R2: a held request freezes the transfer phase
  a_r2_hold_xfer: assert property (@(posedge clk) disable iff (rst)
    (phase == 2'd3 && hold) |=> (phase == 2'd3));

  // R6: the timer flag is only seen while integrating
  a_r6_done_in_integ: assert property (@(posedge clk) disable iff (rst)
    done |-> (phase == 2'd2));

  // R8: integration only continues or moves to transfer
  a_r8_integ_exit: assert property (@(posedge clk) disable iff (rst)
    (phase == 2'd2) |=> (phase == 2'd2 || phase == 2'd3));

  // R8: ready rises only at the end of transfer
  a_r8_ready_after_xfer: assert property (@(posedge clk) disable iff (rst)
    $rose(ready) |-> ($past(phase) == 2'd3));

  // R9: idle is left only on a begin request
  a_r9_idle_stays: assert property (@(posedge clk) disable iff (rst)
    (phase == 2'd0 && !begin_s) |=> (phase == 2'd0));

  // R11: ready is only held in idle
  a_r11_ready_idle: assert property (@(posedge clk) disable iff (rst)
    ready |-> (phase == 2'd0));
endmodule

bind gs_expo_seq gs_expo_seq_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .phase   (phase_o),
  .ready   (ready_o),
  .done    (expo_done_o),
  .hold    (hold),
  .begin_s (begin_s)
);

// File: tb/gs_expo_seq_bench.sv
`timescale 1ns/1ps
module gs_expo_seq_bench;
  localparam int INT_W = 8;
  localparam int SEL_W = 2;
  localparam int NVEC  = 6;
  // {div_sel, length, begin hold cycles}
  localparam logic [13:0] VEC [NVEC] = '{
    {2'd0, 8'd3, 4'd1},
    {2'd1, 8'd5, 4'd2},
    {2'd2, 8'd2, 4'd1},
    {2'd3, 8'd4, 4'd3},
    {2'd0, 8'd1, 4'd5},
    {2'd2, 8'd7, 4'd1}
  };

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [SEL_W-1:0] div_sel = '0;
  logic [INT_W-1:0] expo_len = '0;
  logic             expo_begin = 1'b0;
  logic             expo_end = 1'b0;
  logic             expo_done;
  logic             ready;
  logic [1:0]       phase;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  gs_expo_seq #(.INT_W(INT_W), .SEL_W(SEL_W)) u_gs_expo_seq (
    .clk          (clk),
    .rst          (rst),
    .div_sel_i    (div_sel),
    .expo_len_i   (expo_len),
    .expo_begin_i (expo_begin),
    .expo_end_i   (expo_end),
    .expo_done_o  (expo_done),
    .ready_o      (ready),
    .phase_o      (phase)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  // Begin request held for 'hold' edges, then released.
  task automatic do_begin(input int hold);
    expo_begin = 1'b1;
    repeat (hold) step();
    check(phase == 2'd1, "R11 core reset entered", phase, 1);
    check(ready == 1'b0, "R11 ready cleared", ready, 0);
    expo_begin = 1'b0;
  endtask

  task automatic run_vec(input int r, input int t, input int hold);
    int n;
    int n_int;
    int w;
    n = 0;
    n_int = -1;
    do_begin(hold);
    for (int k = 0; k < 4000; k++) begin
      step();
      n++;
      if (n_int < 0 && phase == 2'd2) n_int = n;
      if (expo_done) break;
    end
    check(n_int == 4 * r, "R4 integration start edge", n_int, 4 * r);
    check(n == (4 + t) * r, "R5 timer edge (R2 R3)", n, (4 + t) * r);
    w = 0;
    for (int k = 0; k < 100; k++) begin
      if (!expo_done) break;
      step();
      w++;
    end
    check(w == r, "R6 timer width", w, r);
    expo_end = 1'b1;
    step();
    check(phase == 2'd3, "R8 transfer entered", phase, 3);
    expo_end = 1'b0;
    n = 0;
    for (int k = 0; k < 200; k++) begin
      step();
      n++;
      if (ready) break;
    end
    check(n == 2 * r, "R8 ready edge", n, 2 * r);
    check(phase == 2'd0, "R8 back to idle", phase, 0);
  endtask

  initial begin
    int n;
    bit seen;
    repeat (3) step();
    rst = 1'b0;
    step();
    // R1 reset state
    check(phase == 2'd0, "R1 phase", phase, 0);
    check(ready == 1'b0, "R1 ready", ready, 0);
    check(expo_done == 1'b0, "R1 timer flag", expo_done, 0);

    for (int i = 0; i < NVEC; i++) begin
      div_sel  = VEC[i][13:12];
      expo_len = VEC[i][11:4];
      run_vec(1 << VEC[i][13:12], int'(VEC[i][11:4]), int'(VEC[i][3:0]));
    end

    // R9: end request in idle with ready set
    expo_end = 1'b1;
    step();
    expo_end = 1'b0;
    repeat (3) step();
    check(phase == 2'd0, "R9 idle phase kept", phase, 0);
    check(ready == 1'b1, "R9 ready kept", ready, 1);

    // R9: end request during core reset
    div_sel  = 2'd1;
    expo_len = 8'd2;
    do_begin(1);
    step();
    expo_end = 1'b1;
    step();
    expo_end = 1'b0;
    step();
    check(phase == 2'd1, "R9 core reset kept", phase, 1);
    seen = 0;
    for (int k = 0; k < 100; k++) begin
      step();
      if (phase == 2'd2) begin
        seen = 1;
        break;
      end
    end
    check(seen, "R9 integration reached", seen, 1);
    rst = 1'b1;
    step();
    rst = 1'b0;
    step();

    // R7: zero length never raises the timer
    div_sel  = 2'd0;
    expo_len = 8'd0;
    do_begin(1);
    seen = 0;
    for (int k = 0; k < 60; k++) begin
      step();
      if (expo_done) seen = 1;
    end
    check(phase == 2'd2, "R7 still integrating", phase, 2);
    check(!seen, "R7 no timer flag", seen, 0);
    // R2: long end hold, transfer still two steps from release
    expo_end = 1'b1;
    repeat (4) step();
    expo_end = 1'b0;
    n = 0;
    for (int k = 0; k < 50; k++) begin
      step();
      n++;
      if (ready) break;
    end
    check(n == 2, "R2 transfer length after long hold", n, 2);

    // R10: begin request during transfer
    div_sel  = 2'd3;
    expo_len = 8'd1;
    do_begin(1);
    for (int k = 0; k < 200; k++) begin
      step();
      if (expo_done) break;
    end
    expo_end = 1'b1;
    step();
    expo_end = 1'b0;
    repeat (2) step();
    check(phase == 2'd3, "R10 still in transfer", phase, 3);
    expo_begin = 1'b1;
    step();
    expo_begin = 1'b0;
    seen = 0;
    for (int k = 0; k < 100; k++) begin
      step();
      if (ready) seen = 1;
      if (phase != 2'd3) break;
    end
    check(phase == 2'd1, "R10 restart into core reset", phase, 1);
    check(!seen, "R10 ready not raised", seen, 0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule